// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block carries words from one clock domain to another. The producer pushes a word by raising a write strobe while the FIFO reports room. The consumer sees each word in an output register. That register is refilled by itself whenever it is empty and storage holds data, so the consumer never has to issue a request just to bring the first word forward.

Each side has its own clock and its own synchronous active-high reset, and the two clocks may be unrelated. Occupancy crosses between the domains as Gray-coded pointers through a chain of flip-flops. Every status flag is a register in the domain of the port that reads it. The write side reports room (`in_ready`) and a nearly-full warning (`almost_full_n`, active LOW). The read side reports a valid output word (`out_ready`) and a nearly-empty warning (`almost_empty_n`, active LOW). Both warning thresholds are parameters.

Top module: `dcfifo_ft`

## Requirements
- R1: Words leave through `rd_data` in the order they were accepted, each exactly once, with no loss and no duplication.
- R2: When `out_ready` is LOW and a word is in storage, the next read-clock edge loads that word into `rd_data` and raises `out_ready` with `rd_en` LOW. With both clocks in phase and two synchronizer stages, a word written into an empty FIFO raises `out_ready` on the third read edge after the write edge.
- R3: While `out_ready` is HIGH and `rd_en` is LOW, `rd_data` and `out_ready` hold their values.
- R4: A write is taken on a write-clock edge only when `wr_en` and `in_ready` are both HIGH. A write strobe while `in_ready` is LOW stores nothing.
- R5: A read is taken on a read-clock edge only when `rd_en` and `out_ready` are both HIGH. A read strobe while `out_ready` is LOW changes nothing.
- R6: Capacity is 2^ADDR_W words, and the word in the output register counts as one of them. `in_ready` goes LOW right after the write edge that fills the last slot.
- R7: `almost_full_n` is LOW exactly when the write side's view of free slots is at or below `AF_GAP`.
- R8: `almost_empty_n` is LOW exactly when the read side's view of held words, counting the output register, is at or below `AE_GAP`.
- R9: The write side sees the space freed by a read through the synchronized pointer. With the clocks in phase, that space is visible to `in_ready` and `almost_full_n` on the third write edge after the read edge.
- R10: Reset gives `out_ready` = 0, `almost_empty_n` = 0, `in_ready` = 0 and `almost_full_n` = 1. After reset is released, `in_ready` first rises on the third write-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active HIGH |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| in_ready | output | 1 | Room for at least one word |
| almost_full_n | output | 1 | LOW when free slots are at or below AF_GAP |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active HIGH |
| rd_en | input | 1 | Read strobe; takes the word in `rd_data` |
| rd_data | output | WIDTH | Output register holding the oldest word |
| out_ready | output | 1 | `rd_data` holds a valid word |
| almost_empty_n | output | 1 | LOW when held words are at or below AE_GAP |

## Verification
The bench drives both ports from one clock so that every crossing has a fixed, known latency. Local effects appear one edge after the strobe: `in_ready` and `almost_full_n` after a write, and `out_ready`, `rd_data` and `almost_empty_n` after a read. Effects that cross domains appear on the third edge: a new word reaching the read side, or freed space reaching the write side. The reference model keeps a three-deep history of the accepted-write and accepted-read totals and uses the entry three edges old for every crossing term. All outputs are sampled on the falling edge that follows each rising edge, so each comparison lands in the cycle in which its result is due.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int unsigned DEF_WIDTH  = 36;
    localparam int unsigned DEF_ADDR_W = 8;
    localparam int unsigned DEF_SYNC   = 2;

    // A port's pair of status flags: the "go" flag and the active-low warning.
    typedef struct packed {
        logic ready;
        logic near_n;
    } flag_pair_t;

    localparam flag_pair_t WR_FLAGS_RST = '{ready: 1'b0, near_n: 1'b1};
    localparam flag_pair_t RD_FLAGS_RST = '{ready: 1'b0, near_n: 1'b0};

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int unsigned W      = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two stages");
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int unsigned W  = 36,
    parameter int unsigned AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int unsigned SLOTS = 1 << AW;

    logic [W-1:0] cells [SLOTS];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned AF_GAP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW:0]   rd_gray_sync,
    output logic [AW:0]   wr_gray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          in_ready,
    output logic          almost_full_n
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    flag_pair_t    flg;
    logic [PW-1:0] wbin, wbin_nx, rd_bin_seen, used_nx;
    logic [1:0]    settle;
    logic          accept;

    assign accept  = push && flg.ready;
    assign wbin_nx = wbin + PW'(accept);

    always_comb begin
        rd_bin_seen[PW-1] = rd_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            rd_bin_seen[i] = rd_bin_seen[i+1] ^ rd_gray_sync[i];
    end

    assign used_nx = wbin_nx - rd_bin_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin    <= '0;
            wr_gray <= '0;
            settle  <= '0;
            flg     <= WR_FLAGS_RST;
        end else begin
            wbin       <= wbin_nx;
            wr_gray    <= wbin_nx ^ (wbin_nx >> 1);
            settle     <= {settle[0], 1'b1};
            flg.ready  <= settle[1] && (used_nx != PW'(DEPTH));
            flg.near_n <= !((PW'(DEPTH) - used_nx) <= PW'(AF_GAP));
        end
    end

    assign we            = accept;
    assign waddr         = wbin[AW-1:0];
    assign in_ready      = flg.ready;
    assign almost_full_n = flg.near_n;

    assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (push && !in_ready) |=> $stable(wbin));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (wbin - rd_bin_seen) <= PW'(DEPTH));

    assert_reset_flags_R10: assert property (@(posedge clk)
        rst |=> (!in_ready && almost_full_n));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int unsigned W      = 36,
    parameter int unsigned AW     = 8,
    parameter int unsigned AE_GAP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic [AW:0]   wr_gray_sync,
    input  logic [W-1:0]  mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output logic [W-1:0]  dout,
    output logic          out_ready,
    output logic          almost_empty_n
);
    localparam int unsigned PW = AW + 1;

    flag_pair_t    flg;
    logic [PW-1:0] load_ptr, cons_ptr, cons_nx, wr_bin_seen, held_nx;
    logic          take, have_word, refill;

    always_comb begin
        wr_bin_seen[PW-1] = wr_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            wr_bin_seen[i] = wr_bin_seen[i+1] ^ wr_gray_sync[i];
    end

    assign take      = pop && flg.ready;
    assign have_word = (wr_bin_seen != load_ptr);
    assign refill    = have_word && (!flg.ready || take);
    assign cons_nx   = cons_ptr + PW'(take);
    assign held_nx   = wr_bin_seen - cons_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_ptr <= '0;
            cons_ptr <= '0;
            rd_gray  <= '0;
            dout     <= '0;
            flg      <= RD_FLAGS_RST;
        end else begin
            cons_ptr   <= cons_nx;
            rd_gray    <= cons_nx ^ (cons_nx >> 1);
            flg.near_n <= !(held_nx <= PW'(AE_GAP));
            if (refill) begin
                dout      <= mem_rdata;
                load_ptr  <= load_ptr + PW'(1);
                flg.ready <= 1'b1;
            end else if (take) begin
                flg.ready <= 1'b0;
            end
        end
    end

    assign raddr          = load_ptr[AW-1:0];
    assign out_ready      = flg.ready;
    assign almost_empty_n = flg.near_n;

    assert_autoload_R2: assert property (@(posedge clk) disable iff (rst)
        (!out_ready && have_word) |=> out_ready);

    assert_hold_output_R3: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !pop) |=> (out_ready && $stable(dout)));

    assert_empty_read_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && !out_ready) |=> $stable(cons_ptr));

    assert_reset_flags_R10: assert property (@(posedge clk)
        rst |=> (!out_ready && !almost_empty_n));
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft
    import dcf_pkg::*;
#(
    parameter int unsigned WIDTH       = DEF_WIDTH,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned AF_GAP      = 4,
    parameter int unsigned AE_GAP      = 4,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             in_ready,
    output logic             almost_full_n,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_ready,
    output logic             almost_empty_n
);
    localparam int unsigned PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray, wr_gray_rd, rd_gray, rd_gray_wr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [WIDTH-1:0]  mem_rdata;

    dcf_wr_side #(.AW(ADDR_W), .AF_GAP(AF_GAP)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .push(wr_en),
        .rd_gray_sync(rd_gray_wr), .wr_gray(wr_gray),
        .we(mem_we), .waddr(mem_waddr),
        .in_ready(in_ready), .almost_full_n(almost_full_n)
    );

    dcf_mem #(.W(WIDTH), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_rd)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_wr)
    );

    dcf_rd_side #(.W(WIDTH), .AW(ADDR_W), .AE_GAP(AE_GAP)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .pop(rd_en),
        .wr_gray_sync(wr_gray_rd), .mem_rdata(mem_rdata),
        .raddr(mem_raddr), .rd_gray(rd_gray), .dout(rd_data),
        .out_ready(out_ready), .almost_empty_n(almost_empty_n)
    );
endmodule

// File: tb/dcfifo_ft_bench.sv
`timescale 1ns/1ps
module dcfifo_ft_bench;
    localparam int W     = 36;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int AF    = 3;
    localparam int AE    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          in_ready, almost_full_n, out_ready, almost_empty_n;
    logic [W-1:0]  rd_data;

    int checks = 0, fails = 0;
    int seq = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dcfifo_ft #(.WIDTH(W), .ADDR_W(AW), .AF_GAP(AF), .AE_GAP(AE), .SYNC_STAGES(2)) u_dcfifo_ft (
        .wr_clk(clk), .wr_rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .in_ready(in_ready), .almost_full_n(almost_full_n),
        .rd_clk(clk), .rd_rst(rst), .rd_en(rd_en), .rd_data(rd_data),
        .out_ready(out_ready), .almost_empty_n(almost_empty_n)
    );

    // Reference model: queue of accepted words plus three-edge histories of
    // the accepted-write and accepted-read totals for the crossing terms.
    logic [W-1:0] q[$];
    logic [W-1:0] m_dout;
    bit  m_in_rdy, m_af_n, m_or, m_ae_n, rd_acc;
    int  wr_tot, rd_tot, loaded, post, wr3, rd3;
    int  wh[3], rh[3];

    always @(posedge clk) begin
        if (rst) begin
            m_in_rdy = 0; m_af_n = 1; m_or = 0; m_ae_n = 0;
            wr_tot = 0; rd_tot = 0; loaded = 0; post = 0; m_dout = '0;
            for (int k = 0; k < 3; k++) begin wh[k] = 0; rh[k] = 0; end
            q.delete();
        end else begin
            wr3 = wh[2];
            rd3 = rh[2];
            post++;
            if (wr_en && m_in_rdy) begin q.push_back(wr_data); wr_tot++; end
            rd_acc = rd_en && m_or;
            if (rd_acc) rd_tot++;
            if ((!m_or || rd_acc) && wr3 > loaded) begin
                m_dout = q[loaded];
                loaded++;
                m_or = 1;
            end else if (rd_acc) begin
                m_or = 0;
            end
            m_in_rdy = (post >= 3) && ((wr_tot - rd3) < DEPTH);
            m_af_n   = !((DEPTH - (wr_tot - rd3)) <= AF);
            m_ae_n   = !((wr3 - rd_tot) <= AE);
            wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = wr_tot;
            rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = rd_tot;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (rst) chk("R10 reset in_ready", 64'(in_ready), 64'(m_in_rdy));
        else     chk("R4 R6 R9 in_ready", 64'(in_ready), 64'(m_in_rdy));
        chk("R7 R9 almost_full_n", 64'(almost_full_n), 64'(m_af_n));
        chk("R2 R5 R10 out_ready", 64'(out_ready), 64'(m_or));
        chk("R8 R10 almost_empty_n", 64'(almost_empty_n), 64'(m_ae_n));
        if (m_or) chk("R1 rd_data", 64'(rd_data), 64'(m_dout));
    endtask

    task automatic step(input bit w, input bit r);
        @(negedge clk);
        compare_all();
        wr_en   = w;
        rd_en   = r;
        seq++;
        wr_data = W'(seq) * W'(36'h9E3779B1) ^ W'(seq);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    logic [W-1:0] held;

    initial begin
        // R10: reset values, then in_ready rising on the third edge
        repeat (3) step(0, 0);
        @(negedge clk); rst = 1'b0;
        repeat (6) step(0, 0);
        // R2: one word into an empty FIFO, autoloaded with no read
        step(1, 0);
        repeat (6) step(0, 0);
        // R4 R6 R7: fill past capacity with no reads
        repeat (30) step(1, 0);
        // R3: hold with no read strobe
        step(0, 0);
        held = rd_data;
        for (int k = 0; k < 5; k++) begin
            step(0, 0);
            chk("R3 rd_data hold", 64'(rd_data), 64'(held));
            chk("R3 out_ready hold", 64'(out_ready), 64'd1);
        end
        // R5 R8 R9: drain, then keep reading an empty FIFO
        repeat (30) step(0, 1);
        // R1: mixed traffic
        for (int k = 0; k < 2000; k++) step(($urandom % 2) == 0, ($urandom % 2) == 0);
        for (int k = 0; k < 500; k++)  step(($urandom % 10) < 9, ($urandom % 10) < 3);
        for (int k = 0; k < 500; k++)  step(($urandom % 10) < 3, ($urandom % 10) < 9);
        repeat (40) step(0, 1);
        done = 1;
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            finish_up();
        end
    end
endmodule